// File: doc/BRIEF.md
# Two-Stage Cascade Noise Cancel and Pruned Comb-Integrator Decimator

This block is the digital back end of a column-shared oversampling converter. Every clock it takes one bit from each of two cascaded single-bit modulator loops. The first loop is second order and the second is first order. The block merges the two bits into one small signed sample. The merge is built so that the coarse loop's quantization error cancels, which leaves third-order shaped noise from the fine loop.

The merged stream feeds a four-stage comb-integrator decimator. Its integrators run every clock, and its combs run once per decimation period. Each stage keeps only the bits its error budget needs. Once per period the block presents a 14-bit signed result together with a one-cycle strobe. The first few results after reset carry a flag that marks them as still settling.

Full scale is fixed by the bit mapping. A merged stream that averages +1 gives a result of +1024, and one that averages −1 gives −1024.

Top module: `mash_cic_decim`

## Requirements
- R1: While `rst_n` is low, which may happen at any time, `res_data` is 0, `res_valid` is 0 and `res_settling` is 1. All cancellation, filter and counter state returns to zero, so results after release behave as if every earlier input were zero.
- R2: The bit value 1 stands for +1 and 0 stands for −1. The merged sample of edge n is c[n] = s1[n−1] + s2[n] − 2·s2[n−1] + s2[n−2]. Terms from before the reset release count as 0. With `mod_s1` held constant, the settled result is +1024 (for 1) or −1024 (for 0) within ±2, whether `mod_s2` is constant or toggles every clock.
- R3: Number the rising edges after reset release from 0. The result produced at edge n equals floor(Σk h[k]·c[n−4−k] / 2^14) to within ±2 LSB. Here h[k] are the coefficients of ((1−z^−64)/(1−z^−1))^4 and the result is two's complement.
- R4: `res_valid` is high for exactly one cycle after each edge n with n mod 64 = 63, so the first strobe follows the 64th edge. It is low after every other edge.
- R5: `res_data` changes only in the cycle in which `res_valid` is high.
- R6: `res_settling` is 1 alongside results 1 to 4 after reset. It is 0 from result 5 on and stays 0 until the next reset.
- R7: Drive the inputs from an ideal cascade of a second-order and a first-order loop, with a constant input of X/1024 of full scale (|X| ≤ 450). The mean of the settled results is then within ±2 of X.
- R8: Results remain within the R3 bound during long runs, after the integrator registers have wrapped many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mod_s1 | input | 1 | Bit from the second-order (first) loop |
| mod_s2 | input | 1 | Bit from the first-order (second) loop |
| res_data | output | 14 | Signed conversion result |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_settling | output | 1 | Marks the first four results after reset |

## Verification
The inputs of edge n first reach the last integrator three edges later. The combs sample that integrator one edge before the strobe edge, so a result produced at edge n draws on samples up to c[n−4]. The result is registered at that edge and read at the following falling edge. The bench therefore records each merged sample under its own edge index and evaluates the direct-form filter sum with that four-edge offset. At every falling edge it checks three things: strobe position, data hold, and the settling flag of each numbered result. The DC means for R7 are taken only over results the flag marks as settled.

// File: rtl/mash_cic_pkg.sv
package mash_cic_pkg;

  // width of the merged cancellation sample (range -5..+5)
  localparam int unsigned NC_W = 4;

  typedef logic signed [1:0] pm1_t;

  function automatic pm1_t bit_to_pm1(input logic b);
    return b ? 2'sb01 : 2'sb11;
  endfunction

  function automatic logic signed [NC_W-1:0] pm1_ext(input pm1_t v);
    return {{(NC_W-2){v[1]}}, v};
  endfunction

endpackage

// File: rtl/mash_nc.sv
module mash_nc
  import mash_cic_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_s1,
  input  logic                   bit_s2,
  output logic signed [NC_W-1:0] nc_val
);

  pm1_t s1_q,  s1_d;
  pm1_t s2_q1, s2_d1;
  pm1_t s2_q2, s2_d2;
  pm1_t s2_now;

  always_comb begin
    s2_now = bit_to_pm1(bit_s2);
    s1_d   = bit_to_pm1(bit_s1);
    s2_d1  = s2_now;
    s2_d2  = s2_q1;
    // coarse loop delayed by one, fine loop through a double difference
    nc_val = pm1_ext(s1_q) + pm1_ext(s2_now)
           - (pm1_ext(s2_q1) <<< 1) + pm1_ext(s2_q2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q1 <= '0;
      s2_q2 <= '0;
    end else begin
      s1_q  <= s1_d;
      s2_q1 <= s2_d1;
      s2_q2 <= s2_d2;
    end
  end

endmodule

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int unsigned IN_W  = 4,
  parameter int unsigned OUT_W = 28,
  parameter int unsigned SHIFT = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);

  localparam int unsigned EXT_W = (IN_W > OUT_W + SHIFT) ? IN_W : OUT_W + SHIFT;

  logic signed [EXT_W-1:0] din_ext;
  logic signed [OUT_W-1:0] term;
  logic signed [OUT_W-1:0] acc_q, acc_d;

  always_comb begin
    din_ext = EXT_W'(din);
    term    = OUT_W'(din_ext >>> SHIFT);
    acc_d   = acc_q + term;          // modular wrap is intended
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign dout = acc_q;

endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int unsigned IN_W  = 28,
  parameter int unsigned OUT_W = 22,
  parameter int unsigned SHIFT = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);

  localparam int unsigned EXT_W = (IN_W > OUT_W + SHIFT) ? IN_W : OUT_W + SHIFT;

  logic signed [EXT_W-1:0] din_ext;
  logic signed [OUT_W-1:0] term;
  logic signed [OUT_W-1:0] dly_q, dly_d;

  always_comb begin
    din_ext = EXT_W'(din);
    term    = OUT_W'(din_ext >>> SHIFT);
    dly_d   = en ? term : dly_q;
    dout    = term - dly_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end

endmodule

// File: rtl/decim_ctr.sv
module decim_ctr #(
  parameter int unsigned RATIO = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);

  localparam int unsigned CNT_W = $clog2(RATIO);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    strobe = (cnt_q == CNT_W'(RATIO - 1));
    cnt_d  = strobe ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n) strobe |=> !strobe); // R4

endmodule

// File: rtl/mash_cic_decim.sv
module mash_cic_decim
  import mash_cic_pkg::*;
#(
  parameter int unsigned RATIO = 64,
  parameter int unsigned NSTG  = 4,
  parameter int unsigned RES_W = 14,
  parameter int unsigned PRUNE [2*NSTG] = '{0, 0, 0, 2, 6, 8, 10, 11}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mod_s1,
  input  logic                    mod_s2,
  output logic signed [RES_W-1:0] res_data,
  output logic                    res_valid,
  output logic                    res_settling
);

  localparam int unsigned ACC_W    = NC_W + NSTG * $clog2(RATIO);
  localparam int unsigned LAST     = 2 * NSTG - 1;
  localparam int unsigned OUT_SH   = ACC_W - RES_W - PRUNE[LAST];
  localparam int unsigned SETTLE_W = $clog2(NSTG + 1);

  logic signed [NC_W-1:0] nc_val;
  logic                   strobe;

  mash_nc u_nc (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_s1 (mod_s1),
    .bit_s2 (mod_s2),
    .nc_val (nc_val)
  );

  decim_ctr #(.RATIO(RATIO)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe)
  );

  for (genvar k = 0; k < 2 * NSTG; k++) begin : g_stg
    localparam int unsigned W = ACC_W - PRUNE[k];
    logic signed [W-1:0] q;
    if (k == 0) begin : g_head
      cic_integ #(.IN_W(NC_W), .OUT_W(W), .SHIFT(PRUNE[0])) u_int (
        .clk(clk), .rst_n(rst_n), .din(nc_val), .dout(q)
      );
    end else if (k < NSTG) begin : g_int
      cic_integ #(.IN_W(ACC_W - PRUNE[k-1]), .OUT_W(W),
                  .SHIFT(PRUNE[k] - PRUNE[k-1])) u_int (
        .clk(clk), .rst_n(rst_n), .din(g_stg[k-1].q), .dout(q)
      );
    end else begin : g_comb
      cic_comb #(.IN_W(ACC_W - PRUNE[k-1]), .OUT_W(W),
                 .SHIFT(PRUNE[k] - PRUNE[k-1])) u_comb (
        .clk(clk), .rst_n(rst_n), .en(strobe), .din(g_stg[k-1].q), .dout(q)
      );
    end
  end

  logic signed [RES_W-1:0] res_fit, res_q, res_d;
  logic                    valid_q, valid_d;
  logic                    settle_q, settle_d;
  logic [SETTLE_W-1:0]     scnt_q, scnt_d;
  logic                    scnt_low;

  always_comb begin
    res_fit  = RES_W'(g_stg[LAST].q >>> OUT_SH);
    scnt_low = (scnt_q < SETTLE_W'(NSTG));
    res_d    = strobe ? res_fit : res_q;
    valid_d  = strobe;
    settle_d = strobe ? scnt_low : settle_q;
    scnt_d   = (strobe && scnt_low) ? scnt_q + 1'b1 : scnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q    <= '0;
      valid_q  <= 1'b0;
      settle_q <= 1'b1;
      scnt_q   <= '0;
    end else begin
      res_q    <= res_d;
      valid_q  <= valid_d;
      settle_q <= settle_d;
      scnt_q   <= scnt_d;
    end
  end

  assign res_data     = res_q;
  assign res_valid    = valid_q;
  assign res_settling = settle_q;

  AST_VALID_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R4
  AST_DATA_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !res_valid |-> $stable(res_data)); // R5
  AST_SETTLE_STAY:  assert property (@(posedge clk) disable iff (!rst_n) !res_settling |=> !res_settling); // R6
  AST_SETTLE_DROP:  assert property (@(posedge clk) disable iff (!rst_n) $fell(res_settling) |-> res_valid); // R6

endmodule

// File: tb/mash_cic_decim_test.sv
module mash_cic_decim_test;

  localparam int RATIO    = 64;
  localparam int NSTG     = 4;
  localparam int RES_W    = 14;
  localparam int SCALE_SH = 4 + NSTG * $clog2(RATIO) - RES_W;
  localparam int H_LEN    = NSTG * (RATIO - 1) + 1;
  localparam int MAXC     = 4096;
  localparam int FS       = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic mod_s1 = 1'b0;
  logic mod_s2 = 1'b0;
  logic signed [RES_W-1:0] res_data;
  logic res_valid;
  logic res_settling;

  mash_cic_decim uut (
    .clk(clk), .rst_n(rst_n), .mod_s1(mod_s1), .mod_s2(mod_s2),
    .res_data(res_data), .res_valid(res_valid), .res_settling(res_settling)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  longint h [H_LEN];
  int cv [MAXC];
  int pa [MAXC];
  int pb [MAXC];
  // behavioural cascade state
  int m_xp, m_e11, m_e12, m_e21;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void build_h();
    longint t [H_LEN];
    int len = 1;
    foreach (h[i]) h[i] = 0;
    h[0] = 1;
    for (int s = 0; s < NSTG; s++) begin
      foreach (t[i]) t[i] = 0;
      for (int i = 0; i < len; i++)
        for (int j = 0; j < RATIO; j++) t[i+j] += h[i];
      len += RATIO - 1;
      foreach (h[i]) h[i] = t[i];
    end
  endfunction

  function automatic longint fir_at(input int n);
    longint acc = 0;
    for (int k = 0; k < H_LEN; k++)
      if (n - 4 - k >= 0) acc += h[k] * cv[n-4-k];
    return acc >>> SCALE_SH;
  endfunction

  task automatic mash_step(input int x, output logic ba, output logic bb);
    int w1, y1, e1, w2, y2, e2;
    w1 = m_xp - 2 * m_e11 + m_e12;
    y1 = (w1 >= 0) ? FS : -FS;
    e1 = y1 - w1;
    w2 = -m_e11 - m_e21;
    y2 = (w2 >= 0) ? FS : -FS;
    e2 = y2 - w2;
    m_e12 = m_e11;
    m_e11 = e1;
    m_e21 = e2;
    m_xp  = x;
    ba = (y1 > 0);
    bb = (y2 > 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(res_data == 0, "R1 data in reset", res_data, 0);
    check(res_valid == 1'b0, "R1 valid in reset", res_valid, 0);
    check(res_settling == 1'b1, "R1 settling in reset", res_settling, 1);
    rst_n = 1'b1;
  endtask

  // mode 0: both ones, 1: both zeros, 2: pseudo-random, 3: cascade model, 4: s1=1, s2 toggles
  task automatic run(input int mode, input int xval, input int nres, input int seed);
    int n = 0;
    int r = 0;
    longint dc_sum = 0;
    longint e;
    longint act;
    logic signed [RES_W-1:0] last = '0;
    logic [15:0] lfsr;
    logic ba, bb, exp_v;
    string tag;
    lfsr  = 16'(seed);
    m_xp  = 0; m_e11 = 0; m_e12 = 0; m_e21 = 0;
    do_reset();
    while (r < nres) begin
      case (mode)
        0: begin ba = 1'b1; bb = 1'b1; end
        1: begin ba = 1'b0; bb = 1'b0; end
        2: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          ba = lfsr[0]; bb = lfsr[5];
        end
        3: mash_step(xval, ba, bb);
        default: begin ba = 1'b1; bb = n[0]; end
      endcase
      mod_s1 = ba;
      mod_s2 = bb;
      pa[n] = ba ? 1 : -1;
      pb[n] = bb ? 1 : -1;
      cv[n] = ((n >= 1) ? pa[n-1] : 0) + pb[n] - 2 * ((n >= 1) ? pb[n-1] : 0)
            + ((n >= 2) ? pb[n-2] : 0);
      @(posedge clk);
      @(negedge clk);
      exp_v = ((n % RATIO) == RATIO - 1);
      check(res_valid == exp_v, "R4 strobe position", res_valid, exp_v);
      if (exp_v) begin
        r++;
        e   = fir_at(n);
        act = res_data;
        tag = (mode == 0 && r > 8) ? "R8 after wrap" : "R3 filtered value";
        check(act - e <= 2 && e - act <= 2, tag, act, e);
        check(res_settling == (r <= NSTG), "R6 settling flag", res_settling, r <= NSTG);
        if (r > NSTG) begin
          if (mode == 3) dc_sum += act;
          if (mode == 0 || mode == 4)
            check(act - FS <= 2 && FS - act <= 2, "R2 cancel high", act, FS);
          if (mode == 1)
            check(act + FS <= 2 && -FS - act <= 2, "R2 cancel low", act, -FS);
        end
        last = res_data;
      end else begin
        check(res_data == last, "R5 data hold", res_data, last);
      end
      n++;
    end
    if (mode == 3)
      check(dc_sum - longint'(nres - NSTG) * xval <= 2 * (nres - NSTG) &&
            longint'(nres - NSTG) * xval - dc_sum <= 2 * (nres - NSTG),
            "R7 dc mean x(results)", dc_sum, longint'(nres - NSTG) * xval);
  endtask

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    build_h();
    run(0, 0, 32, 1);
    run(1, 0, 12, 1);
    run(4, 0, 12, 1);
    run(2, 0, 20, 16'hACE1);
    run(2, 0, 20, 16'h1D2B);
    run(3, -400, 24, 1);
    run(3, -100, 24, 1);
    run(3, 0, 24, 1);
    run(3, 150, 24, 1);
    run(3, 300, 24, 1);
    run(3, 450, 24, 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule